// File: doc/BRIEF.md
# Extended-Hamming Product Code Encoder

This block turns a serial stream of data bits into a two-dimensional product-code block. Each row of data bits is protected by a shortened extended Hamming code. Each column is then protected by a second extended Hamming code, and that column code also covers the row check bits. Bits enter one per clock. The encoded block leaves as a serial stream, row by row, with each row read from left to right and the rows taken from top to bottom.

Data bits are forwarded with a single register of delay. At the end of each data row the encoder stalls its input while it emits the row's Hamming check bits and then the row's even-parity bit. After the last data row it emits the column check rows without taking any input. Each of those rows holds the column check bits followed by the checks on checks.

Both the row length and the number of data rows can be set at run time. This lets one instance serve shortened geometries such as 39×39 and 53×51 built from a 64-bit constituent code. Column check states live in a small memory with one entry per column. That entry is read, advanced and written back for every data bit.

Top module: `pc_prod_enc`

## Requirements
- R1: After a synchronous reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A data bit accepted on a clock edge (`in_valid` and `in_ready` high) appears on `out_bit` with `out_valid` high after exactly one clock.
- R3: After `kx_cfg` data bits of a row, the encoder emits PR row check bits and then one parity bit. The check bits are the remainder of the row message times x^PR divided by the row generator (x^6+x+1 by default), sent highest degree first. The parity bit makes the whole row even.
- R4: Every column of the output block is an extended Hamming codeword of the column generator. Taken top to bottom, it has zero division remainder over its first ky+PC bits and even parity over all its bits.
- R5: After `ky_cfg` data rows, PC+1 check rows follow. Each check row carries `kx_cfg` column check bits, followed by that row's own Hamming checks and parity, which are the checks on checks. A block therefore has `ky_cfg`+PC+1 rows of `kx_cfg`+PR+1 bits.
- R6: `kx_cfg` sets the data bits per row and `ky_cfg` sets the data rows, each from 1 to its maximum. Shortened positions are skipped and are not sent.
- R7: `out_last` is high together with the final bit of a block and at no other time.
- R8: `in_ready` is low while row checks and check rows are emitted. `in_data` and `in_valid` are ignored in that time.
- R9: In a data phase, a cycle without an accepted bit yields `out_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kx_cfg | input | 6 | Data bits per row (1..KX_MAX), held stable during a block |
| ky_cfg | input | 6 | Data rows per block (1..KY_MAX), held stable during a block |
| in_valid | input | 1 | Input bit present |
| in_data | input | 1 | Serial data bit |
| in_ready | output | 1 | Encoder accepts a bit this cycle |
| out_valid | output | 1 | `out_bit` carries an encoded bit |
| out_bit | output | 1 | Serial encoded bit |
| out_last | output | 1 | Final bit of the block |

## Verification
Every output bit is registered once, so an accepted data bit is due exactly one clock after its edge. Row check bits and parity, and the check rows, follow back to back, one per cycle, with no idle cycles. The bench drives inputs on the falling edge and samples outputs on the next falling edge. It compares each valid output with the next entry of a queue built by a behavioural long-division model, so both order and timing are checked. A stall cycle that was driven with junk, or an idle cycle, must then show up as either the expected check bit or `out_valid` low. After each block the bench also checks every received row and column for zero remainder and even parity.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_RCHK = 2'd1,
    PH_CROW = 2'd2
  } pc_phase_t;
endpackage

// File: rtl/pc_lfsr_step.sv
// One step of a systematic cyclic-code division register (P >= 2).
module pc_lfsr_step #(
  parameter int P = 6,
  parameter logic [P-1:0] G = 6'h03
) (
  input  logic [P-1:0] st,
  input  logic         din,
  output logic [P-1:0] nxt
);
  logic fb;
  always_comb begin
    fb  = din ^ st[P-1];
    nxt = {st[P-2:0], 1'b0} ^ (fb ? G : '0);
  end
endmodule

// File: rtl/pc_col_store.sv
// Per-column check state: one write port, asynchronous read.
module pc_col_store #(
  parameter int DEPTH = 57,
  parameter int W     = 7,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R6: writes never leave the configured column range
  p_waddr_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/pc_prod_enc.sv
module pc_prod_enc #(
  parameter int KX_MAX = 57,
  parameter int KY_MAX = 57,
  parameter int PR     = 6,
  parameter int PC     = 6,
  parameter logic [PR-1:0] GR = 6'h03,
  parameter logic [PC-1:0] GC = 6'h03,
  localparam int CXW = $clog2(KX_MAX + 1),
  localparam int CYW = $clog2(KY_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CXW-1:0] kx_cfg,
  input  logic [CYW-1:0] ky_cfg,
  input  logic           in_valid,
  input  logic           in_data,
  output logic           in_ready,
  output logic           out_valid,
  output logic           out_bit,
  output logic           out_last
);
  import pc_pkg::*;

  localparam int AW = (KX_MAX > 1) ? $clog2(KX_MAX) : 1;
  localparam int RW = $clog2(KY_MAX + PC + 2);
  localparam int BW = $clog2(PR + 2);
  localparam int SW = PC + 1;

  pc_phase_t      phase;
  logic [AW-1:0]  col;
  logic [RW-1:0]  row;
  logic [BW-1:0]  bcnt;
  logic [PR-1:0]  row_st;
  logic           row_par;

  logic [SW-1:0]  rd;
  logic [PC-1:0]  rd_st, base_st, col_nx;
  logic           rd_par, base_par;
  logic [PR-1:0]  row_nx;
  logic [RW-1:0]  ky_ext, row_p1, jrow;
  logic           accept, col_last, last_row, crow_bit, feed_bit;

  always_comb begin
    accept   = in_valid && (phase == PH_DATA);
    col_last = (CXW'(col) + CXW'(1)) == kx_cfg;
    ky_ext   = RW'(ky_cfg);
    row_p1   = row + RW'(1);
    last_row = (row == ky_ext + RW'(PC));
    jrow     = row - ky_ext;
    rd_st    = rd[SW-1:1];
    rd_par   = rd[0];
    base_st  = (row == '0) ? '0 : rd_st;
    base_par = (row == '0) ? 1'b0 : rd_par;
    crow_bit = rd_par ^ (^rd_st);
    for (int i = 0; i < PC; i++)
      if (jrow == RW'(PC - 1 - i)) crow_bit = rd_st[i];
    feed_bit = (phase == PH_DATA) ? in_data : crow_bit;
  end

  assign in_ready = (phase == PH_DATA);

  pc_lfsr_step #(.P(PC), .G(GC)) u_col_step (
    .st(base_st), .din(in_data), .nxt(col_nx)
  );

  pc_lfsr_step #(.P(PR), .G(GR)) u_row_step (
    .st(row_st), .din(feed_bit), .nxt(row_nx)
  );

  pc_col_store #(.DEPTH(KX_MAX), .W(SW)) u_store (
    .clk(clk), .rst(rst), .we(accept), .waddr(col),
    .wdata({col_nx, base_par ^ in_data}), .raddr(col), .rdata(rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_DATA;
      col       <= '0;
      row       <= '0;
      bcnt      <= '0;
      row_st    <= '0;
      row_par   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      unique case (phase)
        PH_DATA, PH_CROW: begin
          if (phase == PH_CROW || accept) begin
            out_valid <= 1'b1;
            out_bit   <= feed_bit;
            row_st    <= row_nx;
            row_par   <= row_par ^ feed_bit;
            if (col_last) begin
              col   <= '0;
              bcnt  <= '0;
              phase <= PH_RCHK;
            end else begin
              col <= col + AW'(1);
            end
          end
        end
        PH_RCHK: begin
          out_valid <= 1'b1;
          if (bcnt != BW'(PR)) begin
            out_bit <= row_st[PR-1];
            row_st  <= {row_st[PR-2:0], 1'b0};
            row_par <= row_par ^ row_st[PR-1];
            bcnt    <= bcnt + BW'(1);
          end else begin
            out_bit <= row_par;
            row_st  <= '0;
            row_par <= 1'b0;
            if (last_row) begin
              row      <= '0;
              phase    <= PH_DATA;
              out_last <= 1'b1;
            end else begin
              row   <= row_p1;
              phase <= (row_p1 < ky_ext) ? PH_DATA : PH_CROW;
            end
          end
        end
        default: phase <= PH_DATA;
      endcase
    end
  end

  // R2: accepted bit is forwarded after one register
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_bit == $past(in_data)));
  // R8: a stalled input cycle always produces a check bit next
  p_stall_emits_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);
  // R7: block end marks a valid bit and returns to accepting data
  p_last_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && in_ready));
  // R9: no accepted bit in a data phase gives no output
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/pc_prod_enc_tb.sv
module pc_prod_enc_tb;
  localparam int KX_MAX = 57;
  localparam int KY_MAX = 57;
  localparam int PR = 6;
  localparam int PC = 6;
  localparam logic [7:0] GRF = 8'h43; // x^6+x+1
  localparam logic [7:0] GCF = 8'h43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] kx_cfg = 6'd4;
  logic [5:0] ky_cfg = 6'd4;
  logic in_valid = 1'b0;
  logic in_data = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;

  int n_chk = 0;
  int n_fail = 0;

  bit mat [64][64];
  bit rx  [64][64];
  bit exp_q[$];
  bit dat_q[$];

  always #5 clk = ~clk;

  pc_prod_enc u_dut (
    .clk(clk), .rst(rst), .kx_cfg(kx_cfg), .ky_cfg(ky_cfg),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Long division of msg (first bit = highest degree) times x^p by gfull.
  function automatic logic [7:0] poly_rem(input bit m [128], input int len,
                                          input logic [7:0] gfull, input int p);
    bit a [128];
    logic [7:0] r;
    a = m;
    for (int i = len; i < len + p; i++) a[i] = 1'b0;
    for (int i = 0; i < len; i++)
      if (a[i])
        for (int j = 0; j <= p; j++) a[i+j] = a[i+j] ^ gfull[p-j];
    r = '0;
    for (int k = 0; k < p; k++) r[p-1-k] = a[len+k];
    return r;
  endfunction

  task automatic build(input int kx, input int ky);
    bit m [128];
    logic [7:0] r;
    bit par;
    int nx;
    int ny;
    nx = kx + PR + 1;
    ny = ky + PC + 1;
    exp_q.delete();
    dat_q.delete();
    for (int y = 0; y < ky; y++) begin
      for (int x = 0; x < kx; x++) begin
        mat[y][x] = 1'($urandom);
        dat_q.push_back(mat[y][x]);
        m[x] = mat[y][x];
      end
      r = poly_rem(m, kx, GRF, PR);
      for (int k = 0; k < PR; k++) mat[y][kx+k] = r[PR-1-k];
      par = 1'b0;
      for (int x = 0; x < kx + PR; x++) par ^= mat[y][x];
      mat[y][kx+PR] = par;
    end
    for (int x = 0; x < nx; x++) begin
      for (int y = 0; y < ky; y++) m[y] = mat[y][x];
      r = poly_rem(m, ky, GCF, PC);
      for (int k = 0; k < PC; k++) mat[ky+k][x] = r[PC-1-k];
      par = 1'b0;
      for (int y = 0; y < ky + PC; y++) par ^= mat[y][x];
      mat[ky+PC][x] = par;
    end
    for (int y = 0; y < ny; y++)
      for (int x = 0; x < nx; x++) exp_q.push_back(mat[y][x]);
  endtask

  task automatic run_block(input int kx, input int ky, input bit gaps);
    int nx;
    int ny;
    int n_exp;
    int got;
    int cyc;
    bit idle_prev;
    bit e;
    bit m [128];
    bit par;
    logic [7:0] r;
    string tag;
    nx = kx + PR + 1;
    ny = ky + PC + 1;
    build(kx, ky);
    kx_cfg = 6'(kx);
    ky_cfg = 6'(ky);
    n_exp = exp_q.size();
    got = 0;
    cyc = 0;
    idle_prev = 1'b0;
    while (got < n_exp && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (idle_prev) chk(!out_valid, "R9 idle gives no output", int'(out_valid), 0);
      if (out_valid) begin
        e = exp_q.pop_front();
        if (got / nx >= ky) tag = "R5 check row bit";
        else if (got % nx < kx) tag = "R2 data bit";
        else tag = "R3 row check bit";
        chk(out_bit == e, tag, int'(out_bit), int'(e));
        rx[got / nx][got % nx] = out_bit;
        got++;
        chk(out_last == (got == n_exp), "R7 last flag", int'(out_last), int'(got == n_exp));
      end else begin
        chk(!out_last, "R7 last without valid", int'(out_last), 0);
      end
      idle_prev = 1'b0;
      if (in_ready) begin
        if (dat_q.size() > 0 && !(gaps && ($urandom % 4 == 0))) begin
          in_valid = 1'b1;
          in_data = dat_q.pop_front();
        end else begin
          in_valid = 1'b0;
          in_data = 1'($urandom);
          idle_prev = (dat_q.size() > 0);
        end
      end else begin
        // R8: junk while stalled must not be consumed
        in_valid = 1'b1;
        in_data = 1'($urandom);
      end
    end
    in_valid = 1'b0;
    chk(got == n_exp, "R6 block length", got, n_exp);
    // R3/R4/R5: every row and column of the received block is a codeword
    for (int y = 0; y < ny; y++) begin
      for (int x = 0; x < kx + PR; x++) m[x] = rx[y][x];
      r = poly_rem(m, kx + PR, GRF, 0);
      r = 8'(0);
      for (int x = 0; x < kx; x++) m[x] = rx[y][x];
      r = poly_rem(m, kx, GRF, PR);
      for (int k = 0; k < PR; k++) r[PR-1-k] = r[PR-1-k] ^ rx[y][kx+k];
      par = 1'b0;
      for (int x = 0; x < nx; x++) par ^= rx[y][x];
      chk(r == 8'(0) && !par, "R5 row codeword", int'(r), 0);
    end
    for (int x = 0; x < nx; x++) begin
      for (int y = 0; y < ky; y++) m[y] = rx[y][x];
      r = poly_rem(m, ky, GCF, PC);
      for (int k = 0; k < PC; k++) r[PC-1-k] = r[PC-1-k] ^ rx[ky+k][x];
      par = 1'b0;
      for (int y = 0; y < ny; y++) par ^= rx[y][x];
      chk(r == 8'(0) && !par, "R4 column codeword", int'(r), 0);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
    chk(in_ready, "R1 reset in_ready", int'(in_ready), 1);
    chk(!out_last, "R1 reset out_last", int'(out_last), 0);
    run_block(4, 4, 1'b1);   // R6 small geometry with gaps
    run_block(1, 1, 1'b0);   // R6 minimum geometry
    run_block(32, 32, 1'b1); // R6 39x39 shortened
    run_block(46, 44, 1'b0); // R6 53x51 shortened
    run_block(57, 57, 1'b1); // R6 full 64x64
    run_block(6, 5, 1'b0);
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R9 quiet after blocks", int'(out_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule